// File: doc/BRIEF.md
# Peripheral Control Register with Cross-Domain Reset and Freeze Handshakes

This block holds the module-level control logic of a serial bus controller that spans two clocks. Software on the CPU clock writes a control word to ask for a soft reset or for freeze. Each request crosses into the protocol-engine clock through two-flop synchronizers. The engine answers back across the same kind of path, and the CPU side shows progress in bits that software can poll. Soft reset is a toggle handshake. Freeze is a level handshake: the engine stops its prescaler only when no frame is on the wire and the module is not in a low-power state.

On the CPU side the block also holds a status word with two error-warning flags, and a bus-timing word that soft reset leaves alone. When soft reset completes, the block drives one clear pulse per external register group: timer, error counters, interrupt mask and interrupt flags. It also sends one reset pulse into the engine domain. Some registers are marked protected. While the supervisor bit is set, the block rejects accesses to them that do not carry privilege.

Top module: `modctl_handshake`

## Requirements
- R1: After reset, the control word (address 0) reads 0x0008, which is only the supervisor bit (bit 3) set. The status word (address 1) reads 0. The timing word (address 2) reads 0. Address 3 reads 0. `clr_o` and `presc_stop_o` are 0.
- R2: A permitted write to address 0 with bit 0 set makes control bit 0 read 1 until the soft reset completes, after which it reads 0 on its own. Each completed soft reset produces exactly one `eng_srst_o` pulse in the engine clock and exactly one single-cycle pulse with all bits of `clr_o` set in the CPU clock.
- R3: A one-cycle pulse on `glb_srst_i` starts the same soft-reset sequence as the write in R2.
- R4: Completion of a soft reset clears the freeze request (bit 1) and warning enable (bit 4), and returns the supervisor bit to 1. It keeps module disable (bit 5), clears both status flags, and leaves the timing word unchanged.
- R5: While `lp_mode_i` is 1, a pending soft reset is not launched: bit 0 stays 1 and neither pulse appears. It completes after `lp_mode_i` returns to 0.
- R6: Freeze acknowledge (control bit 2, read-only) and `presc_stop_o` stay 0 while `bus_busy_i` is 1. Once the frame ends, the prescaler stops first and the acknowledge reads 1 after that.
- R7: When the freeze request bit is written to 0, the acknowledge still reads 1 right afterward. It falls only after `presc_stop_o` has gone back to 0.
- R8: A freeze requested while `lp_mode_i` is 1 is not granted until low-power mode ends.
- R9: With the supervisor bit set, a write without `priv_i` to address 0 or 2 is ignored. With the supervisor bit clear, such a write takes effect. Address 1 is never protected.
- R10: With the supervisor bit set, a read without `priv_i` of address 0 or 2 returns 0 and raises `acc_err_o` for the one cycle in which that read data is presented.
- R11: With warning enable set, status bit 0 (transmit) or bit 1 (receive) becomes 1 when its counter input goes from below 96 to 96 or more between two clock edges. Writing 1 to a status bit clears it.
- R12: With warning enable clear, both status flags read 0 and no crossing sets them.
- R13: A soft reset requested while a freeze is pending is served first. It drops the pending freeze, so the prescaler never stops for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-side register clock |
| cpu_rst_n | input | 1 | Active-low asynchronous reset, CPU domain |
| eng_clk | input | 1 | Protocol-engine clock |
| eng_rst_n | input | 1 | Active-low asynchronous reset, engine domain |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| priv_i | input | 1 | Access carries supervisor privilege |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 timing |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after a read strobe |
| acc_err_o | output | 1 | Denied protected read, one cycle |
| glb_srst_i | input | 1 | Chip-level soft-reset request pulse |
| lp_mode_i | input | 1 | Module is in a low-power state |
| tx_ecnt_i | input | CW | Transmit error counter value |
| rx_ecnt_i | input | CW | Receive error counter value |
| bus_busy_i | input | 1 | Frame in progress, engine domain |
| clr_o | output | NCLR | Per-group clear pulses at soft-reset completion |
| eng_srst_o | output | 1 | Soft-reset pulse, engine domain |
| presc_stop_o | output | 1 | Prescaler halted (frozen), engine domain |

## Verification
If the soft-reset launch flag or the toggle parity goes wrong, the effect shows at the ports within a few dozen cycles. Bit 0 then either never clears or clears without a matching clear and engine pulse, and counting pulses per request exposes this. A freeze state that ignores the frame or low-power gate shows up as `presc_stop_o` rising during a held `bus_busy_i` or `lp_mode_i` window. That window is long enough that a synchronizer delay cannot hide it. Faults in the protection decode or the warning edge detector appear on the very next read, so an address-by-privilege sweep and a grid of counter start and end values around 96 pin them down.

// File: rtl/modctl_handshake.sv
module modctl_handshake #(
  parameter int DW       = 16,
  parameter int CW       = 8,
  parameter int WARN_LVL = 96,
  parameter int NCLR     = 4
) (
  input  logic            cpu_clk,
  input  logic            cpu_rst_n,
  input  logic            eng_clk,
  input  logic            eng_rst_n,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic            priv_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            acc_err_o,
  input  logic            glb_srst_i,
  input  logic            lp_mode_i,
  input  logic [CW-1:0]   tx_ecnt_i,
  input  logic [CW-1:0]   rx_ecnt_i,
  input  logic            bus_busy_i,
  output logic [NCLR-1:0] clr_o,
  output logic            eng_srst_o,
  output logic            presc_stop_o
);

  localparam logic [1:0]    A_CTL = 2'd0;
  localparam logic [1:0]    A_STA = 2'd1;
  localparam logic [1:0]    A_TIM = 2'd2;
  localparam logic [CW-1:0] WARN  = CW'(WARN_LVL);

  // CPU domain state
  logic          srst_pend, srst_go, req_t;
  logic          frz_req, supv, warn_en, mod_dis;
  logic [1:0]    flags;
  logic [DW-1:0] tim;
  logic [CW-1:0] tx_q, rx_q;
  logic          a1, a2, k1, k2;

  // engine domain state
  logic r1, r2, r3, e_ack, f1, f2, l1, l2, frz_st;

  wire deny      = (addr_i == A_CTL || addr_i == A_TIM) && supv && !priv_i;
  wire wr_ok     = wr_en_i && !deny;
  wire ctl_wr    = wr_ok && addr_i == A_CTL;
  wire srst_set  = glb_srst_i || (ctl_wr && wdata_i[0]);
  wire launch    = srst_pend && !srst_go && !lp_mode_i;
  wire srst_done = srst_go && (a2 == req_t);
  wire frz_eff   = frz_req && !srst_pend;

  wire       tx_x = warn_en && tx_q < WARN && tx_ecnt_i >= WARN;
  wire       rx_x = warn_en && rx_q < WARN && rx_ecnt_i >= WARN;
  wire [1:0] w1c  = (wr_ok && addr_i == A_STA) ? wdata_i[1:0] : 2'b00;
  wire [1:0] flags_n = warn_en ? ((flags & ~w1c) | {rx_x, tx_x}) : 2'b00;

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (addr_i)
      A_CTL:   rd_mux = DW'({mod_dis, warn_en, supv, k2, frz_req, srst_pend});
      A_STA:   rd_mux = DW'(flags & {2{warn_en}});
      A_TIM:   rd_mux = tim;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      srst_pend <= 1'b0;
      srst_go   <= 1'b0;
      req_t     <= 1'b0;
      frz_req   <= 1'b0;
      supv      <= 1'b1;
      warn_en   <= 1'b0;
      mod_dis   <= 1'b0;
      flags     <= 2'b00;
      tim       <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else begin
      tx_q <= tx_ecnt_i;
      rx_q <= rx_ecnt_i;
      if (wr_ok && addr_i == A_TIM) tim <= wdata_i;
      if (srst_done) begin
        srst_pend <= srst_set;
        srst_go   <= 1'b0;
        frz_req   <= 1'b0;
        supv      <= 1'b1;
        warn_en   <= 1'b0;
        flags     <= 2'b00;
      end else begin
        if (ctl_wr) begin
          frz_req <= wdata_i[1];
          supv    <= wdata_i[3];
          warn_en <= wdata_i[4];
          mod_dis <= wdata_i[5];
        end
        if (srst_set) srst_pend <= 1'b1;
        if (launch) begin
          req_t   <= ~req_t;
          srst_go <= 1'b1;
        end
        flags <= flags_n;
      end
    end
  end

  always_ff @(posedge cpu_clk or negedge cpu_rst_n) begin
    if (!cpu_rst_n) begin
      a1 <= 1'b0; a2 <= 1'b0; k1 <= 1'b0; k2 <= 1'b0;
      clr_o     <= '0;
      rdata_o   <= '0;
      acc_err_o <= 1'b0;
    end else begin
      a1 <= e_ack; a2 <= a1;
      k1 <= frz_st; k2 <= k1;
      clr_o     <= {NCLR{srst_done}};
      acc_err_o <= rd_en_i && deny;
      if (rd_en_i) rdata_o <= deny ? '0 : rd_mux;
    end
  end

  wire eng_hit = r2 ^ r3;

  always_ff @(posedge eng_clk or negedge eng_rst_n) begin
    if (!eng_rst_n) begin
      r1 <= 1'b0; r2 <= 1'b0; r3 <= 1'b0; e_ack <= 1'b0;
      f1 <= 1'b0; f2 <= 1'b0; l1 <= 1'b0; l2 <= 1'b0;
      frz_st     <= 1'b0;
      eng_srst_o <= 1'b0;
    end else begin
      r1 <= req_t; r2 <= r1; r3 <= r2;
      e_ack      <= r3;
      eng_srst_o <= eng_hit;
      f1 <= frz_eff; f2 <= f1;
      l1 <= lp_mode_i; l2 <= l1;
      if (eng_hit || !f2)                   frz_st <= 1'b0;
      else if (!bus_busy_i && !l2)          frz_st <= 1'b1;
    end
  end

  assign presc_stop_o = frz_st;

  // R5
  lp_hold_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    lp_mode_i && srst_pend && !srst_go |=> srst_pend);

  // R2
  clr_pulse_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    clr_o[0] |=> !clr_o[0]);

  // R10
  deny_rd_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    acc_err_o |-> rdata_o == '0);

  // R9
  tim_guard_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    wr_en_i && !priv_i && supv && addr_i == A_TIM |=> $stable(tim));

  // R12
  warn_off_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    !warn_en |=> flags == 2'b00);

  // R6
  busy_hold_chk: assert property (@(posedge eng_clk) disable iff (!eng_rst_n)
    !frz_st && bus_busy_i |=> !frz_st);

endmodule

// File: tb/test_modctl_handshake.sv
`timescale 1ns/1ps
module test_modctl_handshake;
  localparam int DW = 16, CW = 8, NCLR = 4;

  logic cpu_clk = 0, eng_clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, priv = 1, glb = 0, lp = 0, busy = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic acc_err, eng_srst, presc;
  logic [CW-1:0] tx = 0, rx = 0;
  logic [NCLR-1:0] clr;

  always #2.5 cpu_clk = ~cpu_clk;
  always #3.5 eng_clk = ~eng_clk;

  modctl_handshake #(.DW(DW), .CW(CW), .WARN_LVL(96), .NCLR(NCLR)) i_modctl_handshake (
    .cpu_clk(cpu_clk), .cpu_rst_n(rst_n), .eng_clk(eng_clk), .eng_rst_n(rst_n),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .priv_i(priv), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .acc_err_o(acc_err), .glb_srst_i(glb), .lp_mode_i(lp),
    .tx_ecnt_i(tx), .rx_ecnt_i(rx), .bus_busy_i(busy), .clr_o(clr),
    .eng_srst_o(eng_srst), .presc_stop_o(presc));

  int checks = 0, fails = 0, cyc = 0;
  int clr_full = 0, clr_part = 0, eng_cnt = 0;

  always @(posedge cpu_clk) begin
    if (clr == '1) clr_full++;
    else if (clr != '0) clr_part++;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
  always @(posedge eng_clk) if (eng_srst) eng_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge cpu_clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input logic p);
    @(negedge cpu_clk);
    addr = a; wdata = d; priv = p; wr_en = 1;
    @(negedge cpu_clk);
    wr_en = 0; priv = 1;
  endtask

  task automatic rd(input logic [1:0] a, input logic p, output logic [DW-1:0] d, output logic e);
    @(negedge cpu_clk);
    addr = a; priv = p; rd_en = 1;
    @(posedge cpu_clk); #1;
    d = rdata; e = acc_err;
    @(negedge cpu_clk);
    rd_en = 0; priv = 1;
  endtask

  task automatic wait_ctl(input int bitn, input logic val, input string req);
    logic [DW-1:0] d; logic e;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, 1'b1, d, e);
      if (d[bitn] == val) break;
    end
    chk(req, 32'(d[bitn]), 32'(val));
  endtask

  initial begin
    logic [DW-1:0] d; logic e;
    int c0, e0;
    idle(5);
    rst_n = 1;
    idle(2);

    // R1 and R10: reset state and protection sweep, supervisor bit set
    chk("R1 presc", 32'(presc), 0);
    chk("R1 clr", 32'(clr), 0);
    for (int a = 0; a < 4; a++) begin
      for (int p = 0; p < 2; p++) begin
        logic den;
        den = (a == 0 || a == 2) && p == 0;
        rd(2'(a), 1'(p), d, e);
        chk(den ? "R10 data" : "R1 data", 32'(d), (a == 0 && !den) ? 32'h8 : 32'h0);
        chk("R10 err", 32'(e), 32'(den));
      end
    end
    rd(2'd0, 1'b0, d, e);
    @(posedge cpu_clk); #1;
    chk("R10 one-cycle err", 32'(acc_err), 0);

    // R9
    wr(2'd2, 16'h1234, 1'b0);
    rd(2'd2, 1'b1, d, e);  chk("R9 denied tim write", 32'(d), 0);
    wr(2'd0, 16'h0010, 1'b0);
    rd(2'd0, 1'b1, d, e);  chk("R9 denied ctl write", 32'(d), 32'h8);
    wr(2'd2, 16'hBEEF, 1'b1);
    rd(2'd2, 1'b1, d, e);  chk("R9 priv tim write", 32'(d), 32'hBEEF);
    wr(2'd0, 16'h0000, 1'b1);
    wr(2'd2, 16'h0042, 1'b0);
    rd(2'd2, 1'b0, d, e);  chk("R9 open tim write", 32'(d), 32'h42);
    chk("R9 open read no err", 32'(e), 0);
    wr(2'd0, 16'h0018, 1'b0);
    rd(2'd0, 1'b1, d, e);  chk("R9 open ctl write", 32'(d), 32'h18);

    // R11: crossing grid on transmit counter
    for (int s = 90; s < 96; s++) begin
      for (int t = 94; t <= 100; t++) begin
        tx = 8'(s); idle(2);
        tx = 8'(t); idle(2);
        rd(2'd1, 1'b0, d, e);
        chk("R11 tx crossing", 32'(d), (s < 96 && t >= 96) ? 32'h1 : 32'h0);
        wr(2'd1, 16'h3, 1'b0);
        tx = 0; idle(2);
      end
    end
    rd(2'd1, 1'b0, d, e);  chk("R11 w1c", 32'(d), 0);
    rx = 95; idle(2); rx = 96; idle(2);
    rd(2'd1, 1'b0, d, e);  chk("R11 rx crossing", 32'(d), 32'h2);
    wr(2'd1, 16'h2, 1'b0); rx = 0; idle(2);

    // R12
    wr(2'd0, 16'h0008, 1'b1);
    tx = 100; idle(2);
    rd(2'd1, 1'b0, d, e);  chk("R12 disabled read", 32'(d), 0);
    wr(2'd0, 16'h0018, 1'b1);
    rd(2'd1, 1'b0, d, e);  chk("R12 no stale flag", 32'(d), 0);
    tx = 0; idle(2);

    // R2 and R4: write-initiated soft reset
    wr(2'd2, 16'h5A5A, 1'b1);
    wr(2'd0, 16'h0038, 1'b1);
    tx = 100; idle(2); tx = 0; idle(2);
    rd(2'd1, 1'b1, d, e);  chk("R11 flag before reset", 32'(d), 32'h1);
    c0 = clr_full; e0 = eng_cnt;
    wr(2'd0, 16'h0039, 1'b1);
    rd(2'd0, 1'b1, d, e);  chk("R2 pending bit", 32'(d[0]), 1);
    wait_ctl(0, 1'b0, "R2 self-clear");
    idle(3);
    chk("R2 clr pulses", 32'(clr_full - c0), 1);
    chk("R2 partial clr", 32'(clr_part), 0);
    chk("R2 engine pulses", 32'(eng_cnt - e0), 1);
    rd(2'd0, 1'b1, d, e);  chk("R4 ctl after reset", 32'(d), 32'h28);
    rd(2'd1, 1'b1, d, e);  chk("R4 status cleared", 32'(d), 0);
    rd(2'd2, 1'b1, d, e);  chk("R4 timing kept", 32'(d), 32'h5A5A);

    // R3: global request
    c0 = clr_full; e0 = eng_cnt;
    @(negedge cpu_clk); glb = 1; @(negedge cpu_clk); glb = 0;
    rd(2'd0, 1'b1, d, e);  chk("R3 pending bit", 32'(d[0]), 1);
    wait_ctl(0, 1'b0, "R3 self-clear");
    idle(3);
    chk("R3 clr pulses", 32'(clr_full - c0), 1);
    chk("R3 engine pulses", 32'(eng_cnt - e0), 1);

    // R5: low-power blocks soft reset
    c0 = clr_full; e0 = eng_cnt;
    lp = 1;
    wr(2'd0, 16'h0009, 1'b1);
    idle(40);
    rd(2'd0, 1'b1, d, e);  chk("R5 still pending", 32'(d[0]), 1);
    chk("R5 no engine pulse", 32'(eng_cnt - e0), 0);
    chk("R5 no clr pulse", 32'(clr_full - c0), 0);
    lp = 0;
    wait_ctl(0, 1'b0, "R5 completes after exit");
    idle(3);
    chk("R5 clr after exit", 32'(clr_full - c0), 1);

    // R6: freeze waits for frame end
    busy = 1;
    wr(2'd0, 16'h000A, 1'b1);
    idle(30);
    chk("R6 presc held", 32'(presc), 0);
    rd(2'd0, 1'b1, d, e);  chk("R6 ack held", 32'(d[2]), 0);
    busy = 0;
    wait_ctl(2, 1'b1, "R6 ack granted");
    chk("R6 presc stopped", 32'(presc), 1);

    // R7: withdraw
    wr(2'd0, 16'h0008, 1'b1);
    rd(2'd0, 1'b1, d, e);  chk("R7 ack lingers", 32'(d[2]), 1);
    wait_ctl(2, 1'b0, "R7 ack clears");
    chk("R7 presc running", 32'(presc), 0);

    // R8: freeze during low power
    lp = 1;
    wr(2'd0, 16'h000A, 1'b1);
    idle(40);
    rd(2'd0, 1'b1, d, e);  chk("R8 ack held", 32'(d[2]), 0);
    chk("R8 presc held", 32'(presc), 0);
    lp = 0;
    wait_ctl(2, 1'b1, "R8 ack after exit");
    wr(2'd0, 16'h0008, 1'b1);
    wait_ctl(2, 1'b0, "R8 withdraw");

    // R13: soft reset overrides pending freeze
    busy = 1;
    wr(2'd0, 16'h000A, 1'b1);
    idle(10);
    wr(2'd0, 16'h000B, 1'b1);
    wait_ctl(0, 1'b0, "R13 reset served");
    rd(2'd0, 1'b1, d, e);  chk("R13 freeze dropped", 32'(d), 32'h8);
    busy = 0;
    idle(30);
    chk("R13 presc never stops", 32'(presc), 0);
    rd(2'd0, 1'b1, d, e);  chk("R13 no ack", 32'(d[2]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule